// File: doc/BRIEF.md
# Limit-Violation Interrupt Status Controller

This block sits behind the comparison logic of a hardware monitor. Each cycle it takes two 8-bit vectors of out-of-limit flags, one bit per monitored channel, and latches them into two sticky status registers. Each status register has its own mask register. Any unmasked status bit drives an active-low interrupt output.

A configuration register controls the block. Its fields start or stop monitoring, gate the interrupt output, and release the interrupt while freezing monitoring. It also holds two self-clearing commands. One restores the register defaults. The other emits a long, fixed-length active-low reset pulse.

A separate thermal event input latches an active-low thermal alert output, which has its own release command. Software reaches every register through a flat single-cycle read/write port. A read of a status register clears the bits that the read returned. If another status register still holds unmasked events after that read, the interrupt is raised again.

Top module: `limit_irq_ctrl`

## Requirements
- R1: After reset the configuration register (address 40h) reads 08h, both status registers (41h, 42h) and both mask registers (43h, 44h) read 00h, and irq_no_o, therm_no_o and rst_pulse_no_o are all high.
- R2: Monitoring is active when configuration bit 0 (start) is 1 and bit 3 (interrupt release) is 0. While monitoring is active, every flag bit on viol1_i / viol2_i that is high at a clock edge is OR-ed into the same bit of status register 41h / 42h. While monitoring is inactive the flags are not recorded.
- R3: A read of 41h or 42h returns the current contents and clears exactly those bits at that edge. A flag that arrives in the same cycle as the read remains set afterwards.
- R4: A mask bit set to 1 (43h for status 41h, 44h for 42h) keeps that status bit from asserting irq_no_o, while the status bit still records the event.
- R5: irq_no_o goes low one cycle after any status bit is set with its mask bit at 0, provided configuration bit 1 (interrupt enable) is 1 and bit 3 is 0. With bit 1 at 0, irq_no_o stays high.
- R6: In the cycle after a status register read, irq_no_o is high. If unmasked status bits remain, irq_no_o goes low again one cycle later.
- R7: Writing configuration bit 0 to 0 while an interrupt is pending does not release irq_no_o.
- R8: While configuration bit 3 is 1, irq_no_o is high, the status contents are unchanged, and no new flags are recorded.
- R9: A pulse on therm_evt_i during active monitoring drives therm_no_o low until a configuration write with bit 5 at 1. That write releases the output and leaves the status registers unchanged. Bit 5 always reads 0.
- R10: Writing configuration bit 7 at 1 restores configuration 08h and clears both status and both mask registers and the thermal alert. Bit 7 reads 0.
- R11: Writing configuration bit 4 at 1 drives rst_pulse_no_o low for CLK_HZ/1000*PULSE_MS cycles, starting at the write edge. Bit 4 reads 1 for the length of the pulse and 0 once it ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| viol1_i | input | 8 | Out-of-limit flags for status register 1 |
| viol2_i | input | 8 | Out-of-limit flags for status register 2 |
| therm_evt_i | input | 1 | Thermal event flag |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_addr_i | input | 8 | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, combinational from address |
| irq_no_o | output | 1 | Active-low interrupt |
| therm_no_o | output | 1 | Active-low thermal alert |
| rst_pulse_no_o | output | 1 | Active-low timed reset pulse |

## Verification
The bench builds the block with CLK_HZ=1000 and PULSE_MS=45. These values shrink the reset pulse to 45 cycles, so the bench can count the whole pulse on rst_pulse_no_o from the write edge to its release and check the self-clearing readback on both sides. With the default 100 MHz setting the pulse would last 4.5 million cycles, which is beyond the run length.

// File: rtl/limit_irq_pkg.sv
package limit_irq_pkg;
  localparam int unsigned REG_W  = 8;
  localparam int unsigned NBANK  = 2;

  localparam logic [7:0] ADDR_CFG  = 8'h40;
  localparam logic [7:0] ADDR_ST0  = 8'h41;
  localparam logic [7:0] ADDR_MSK0 = 8'h43;

  localparam logic [7:0] CFG_RST   = 8'h08;
  localparam logic [7:0] CFG_STORE = 8'h0B;  // bits held in flops

  localparam int CFG_START  = 0;
  localparam int CFG_IRQ_EN = 1;
  localparam int CFG_REL    = 3;
  localparam int CFG_PULSE  = 4;
  localparam int CFG_TCLR   = 5;
  localparam int CFG_INIT   = 7;
endpackage

// File: rtl/limit_stat_bank.sv
module limit_stat_bank #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         init_i,
  input  logic         mon_i,
  input  logic         rd_i,
  input  logic         mask_we_i,
  input  logic [W-1:0] viol_i,
  input  logic [W-1:0] mask_wdata_i,
  output logic [W-1:0] stat_o,
  output logic [W-1:0] mask_o,
  output logic         pend_o
);
  logic [W-1:0] stat_q, mask_q, clr_bits, set_bits;

  assign clr_bits = rd_i  ? stat_q : '0;
  assign set_bits = mon_i ? viol_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      mask_q <= '0;
    end else if (init_i) begin
      stat_q <= '0;
      mask_q <= '0;
    end else begin
      stat_q <= (stat_q & ~clr_bits) | set_bits;  // set beats clear
      if (mask_we_i) mask_q <= mask_wdata_i;
    end
  end

  assign stat_o = stat_q;
  assign mask_o = mask_q;
  assign pend_o = |(stat_q & ~mask_q);

  AST_SET_RECORDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mon_i && !init_i) |=> ((stat_o & $past(viol_i)) == $past(viol_i))); // R2
  AST_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !mon_i && !init_i) |=> (stat_o == '0)); // R3
  AST_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mon_i && !rd_i && !init_i) |=> $stable(stat_o)); // R8
endmodule

// File: rtl/limit_pulse_gen.sv
module limit_pulse_gen #(
  parameter int unsigned LEN = 45
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic abort_i,
  output logic busy_o
);
  localparam int unsigned CW = $clog2(LEN + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (abort_i)                  cnt_q <= '0;
    else if (start_i && cnt_q == '0)   cnt_q <= CW'(LEN);
    else if (cnt_q != '0)              cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  AST_PULSE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !abort_i && cnt_q > 1) |=> busy_o); // R11
  AST_PULSE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> !busy_o); // R11
endmodule

// File: rtl/limit_irq_ctrl.sv
module limit_irq_ctrl
  import limit_irq_pkg::*;
#(
  parameter int unsigned CLK_HZ   = 100_000_000,
  parameter int unsigned PULSE_MS = 45
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] viol1_i,
  input  logic [7:0] viol2_i,
  input  logic       therm_evt_i,
  input  logic       reg_we_i,
  input  logic       reg_re_i,
  input  logic [7:0] reg_addr_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  output logic       irq_no_o,
  output logic       therm_no_o,
  output logic       rst_pulse_no_o
);
  localparam int unsigned PULSE_CYC = CLK_HZ / 1000 * PULSE_MS;

  logic [7:0] cfg_q;
  logic       cfg_wr, init_cmd, tclr_cmd, pulse_cmd, pulse_busy;
  logic       mon, st_rd, any_pend, irq_no_q, therm_q;

  logic [NBANK-1:0][REG_W-1:0] viol_a, stat_a, mask_a;
  logic [NBANK-1:0]            pend_a, rd_a, mwe_a;

  assign viol_a[0] = viol1_i;
  assign viol_a[1] = viol2_i;

  assign cfg_wr    = reg_we_i && reg_addr_i == ADDR_CFG;
  assign init_cmd  = cfg_wr && reg_wdata_i[CFG_INIT];
  assign tclr_cmd  = cfg_wr && !reg_wdata_i[CFG_INIT] && reg_wdata_i[CFG_TCLR];
  assign pulse_cmd = cfg_wr && !reg_wdata_i[CFG_INIT] && reg_wdata_i[CFG_PULSE];
  assign mon       = cfg_q[CFG_START] && !cfg_q[CFG_REL];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cfg_q <= CFG_RST;
    else if (init_cmd) cfg_q <= CFG_RST;
    else if (cfg_wr)   cfg_q <= reg_wdata_i & CFG_STORE;
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    localparam logic [7:0] A_ST  = ADDR_ST0 + 8'(b);
    localparam logic [7:0] A_MSK = ADDR_MSK0 + 8'(b);
    assign rd_a[b]  = reg_re_i && reg_addr_i == A_ST;
    assign mwe_a[b] = reg_we_i && reg_addr_i == A_MSK;
    limit_stat_bank #(.W(REG_W)) i_bank (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .init_i       (init_cmd),
      .mon_i        (mon),
      .rd_i         (rd_a[b]),
      .mask_we_i    (mwe_a[b]),
      .viol_i       (viol_a[b]),
      .mask_wdata_i (reg_wdata_i),
      .stat_o       (stat_a[b]),
      .mask_o       (mask_a[b]),
      .pend_o       (pend_a[b])
    );
  end

  assign st_rd    = |rd_a;
  assign any_pend = |pend_a;

  // a status read opens a one-cycle gap so remaining events re-raise the line
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_no_q <= 1'b1;
    else         irq_no_q <= !(any_pend && cfg_q[CFG_IRQ_EN] && !cfg_q[CFG_REL] && !st_rd);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       therm_q <= 1'b0;
    else if (init_cmd) therm_q <= 1'b0;
    else               therm_q <= (therm_q && !tclr_cmd) || (therm_evt_i && mon);
  end

  limit_pulse_gen #(.LEN(PULSE_CYC)) i_pulse (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (pulse_cmd),
    .abort_i (init_cmd),
    .busy_o  (pulse_busy)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == ADDR_CFG) begin
      reg_rdata_o = cfg_q;
      reg_rdata_o[CFG_PULSE] = pulse_busy;
    end
    for (int b = 0; b < NBANK; b++) begin
      if (reg_addr_i == ADDR_ST0 + 8'(b))  reg_rdata_o = stat_a[b];
      if (reg_addr_i == ADDR_MSK0 + 8'(b)) reg_rdata_o = mask_a[b];
    end
  end

  assign irq_no_o       = irq_no_q;
  assign therm_no_o     = !therm_q;
  assign rst_pulse_no_o = !pulse_busy;

  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_q[CFG_IRQ_EN] || cfg_q[CFG_REL]) |=> irq_no_o); // R5 R8
  AST_READ_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_rd |=> irq_no_o); // R6
  AST_INIT_DEFAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_cmd |=> (cfg_q == CFG_RST && therm_no_o)); // R10
  AST_THERM_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tclr_cmd && !therm_evt_i) |=> therm_no_o); // R9
endmodule

// File: tb/test_limit_irq_ctrl.sv
module test_limit_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] viol1 = '0, viol2 = '0;
  logic       therm_evt = 1'b0;
  logic       we = 1'b0, re = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic [7:0] rdata;
  logic       irq_n, therm_n, rstp_n;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  limit_irq_ctrl #(.CLK_HZ(1000), .PULSE_MS(45)) i_limit_irq_ctrl (
    .clk_i (clk), .rst_ni (rst_n),
    .viol1_i (viol1), .viol2_i (viol2), .therm_evt_i (therm_evt),
    .reg_we_i (we), .reg_re_i (re), .reg_addr_i (addr),
    .reg_wdata_i (wdata), .reg_rdata_o (rdata),
    .irq_no_o (irq_n), .therm_no_o (therm_n), .rst_pulse_no_o (rstp_n)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); re = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk); re = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] v1, input logic [7:0] v2, input logic t);
    @(negedge clk); viol1 = v1; viol2 = v2; therm_evt = t;
    @(negedge clk); viol1 = '0; viol2 = '0; therm_evt = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(8'h40, d); chk("R1 cfg", d, 8'h08);
    rd(8'h41, d); chk("R1 st1", d, 8'h00);
    rd(8'h42, d); chk("R1 st2", d, 8'h00);
    rd(8'h43, d); chk("R1 msk1", d, 8'h00);
    rd(8'h44, d); chk("R1 msk2", d, 8'h00);
    chk("R1 outs", {5'd0, irq_n, therm_n, rstp_n}, 8'h07);
  endtask

  task automatic t_latch();
    logic [7:0] d;
    wr(8'h40, 8'h03);
    pulse(8'h05, 8'h00, 1'b0);
    rd(8'h41, d); chk("R2 latch", d, 8'h05);
    rd(8'h41, d); chk("R3 cleared", d, 8'h00);
    wr(8'h40, 8'h02);
    pulse(8'h01, 8'h00, 1'b0);
    rd(8'h41, d); chk("R2 standby", d, 8'h00);
    wr(8'h40, 8'h03);
  endtask

  task automatic t_irq();
    logic [7:0] d;
    pulse(8'h10, 8'h00, 1'b0);
    @(negedge clk); chk("R5 asserted", {7'd0, irq_n}, 8'h00);
    wr(8'h40, 8'h01);
    @(negedge clk); chk("R5 disabled", {7'd0, irq_n}, 8'h01);
    wr(8'h40, 8'h03);
    @(negedge clk); chk("R5 re-enabled", {7'd0, irq_n}, 8'h00);
    wr(8'h40, 8'h02);
    @(negedge clk); chk("R7 start off keeps irq", {7'd0, irq_n}, 8'h00);
    wr(8'h40, 8'h03);
    rd(8'h41, d); chk("R7 st1", d, 8'h10);
  endtask

  task automatic t_rearm();
    logic [7:0] d;
    pulse(8'h01, 8'h80, 1'b0);
    @(negedge clk); chk("R6 pending", {7'd0, irq_n}, 8'h00);
    rd(8'h41, d); chk("R6 st1", d, 8'h01);
    chk("R6 gap", {7'd0, irq_n}, 8'h01);
    @(negedge clk); chk("R6 re-raised", {7'd0, irq_n}, 8'h00);
    rd(8'h42, d); chk("R6 st2", d, 8'h80);
    @(negedge clk); chk("R6 idle", {7'd0, irq_n}, 8'h01);
  endtask

  task automatic t_mask();
    logic [7:0] d;
    wr(8'h43, 8'h04);
    pulse(8'h04, 8'h00, 1'b0);
    @(negedge clk); @(negedge clk);
    chk("R4 masked irq", {7'd0, irq_n}, 8'h01);
    rd(8'h41, d); chk("R4 still recorded", d, 8'h04);
    wr(8'h43, 8'h00);
  endtask

  task automatic t_set_wins();
    logic [7:0] d;
    pulse(8'h08, 8'h00, 1'b0);
    @(negedge clk); re = 1'b1; addr = 8'h41; viol1 = 8'h08;
    #1 d = rdata;
    @(negedge clk); re = 1'b0; viol1 = '0;
    chk("R3 read value", d, 8'h08);
    rd(8'h41, d); chk("R3 set wins", d, 8'h08);
  endtask

  task automatic t_release();
    logic [7:0] d;
    pulse(8'h20, 8'h00, 1'b0);
    @(negedge clk); chk("R8 pending", {7'd0, irq_n}, 8'h00);
    wr(8'h40, 8'h0B);
    @(negedge clk); chk("R8 released", {7'd0, irq_n}, 8'h01);
    pulse(8'h40, 8'h00, 1'b0);
    wr(8'h40, 8'h03);
    rd(8'h41, d); chk("R8 status frozen", d, 8'h20);
  endtask

  task automatic t_therm();
    logic [7:0] d;
    pulse(8'h01, 8'h00, 1'b1);
    chk("R9 alert", {7'd0, therm_n}, 8'h00);
    wr(8'h40, 8'h23);
    chk("R9 cleared", {7'd0, therm_n}, 8'h01);
    rd(8'h40, d); chk("R9 bit5 reads 0", d, 8'h03);
    rd(8'h41, d); chk("R9 status kept", d, 8'h01);
  endtask

  task automatic t_init();
    logic [7:0] d;
    wr(8'h44, 8'h55);
    pulse(8'h00, 8'h02, 1'b1);
    wr(8'h40, 8'h80);
    rd(8'h40, d); chk("R10 cfg", d, 8'h08);
    rd(8'h44, d); chk("R10 msk2", d, 8'h00);
    rd(8'h42, d); chk("R10 st2", d, 8'h00);
    chk("R10 therm", {7'd0, therm_n}, 8'h01);
    wr(8'h40, 8'h03);
  endtask

  task automatic t_pulse();
    int n;
    wr(8'h40, 8'h13);
    re = 1'b1; addr = 8'h40;
    #1 chk("R11 bit4 set", rdata, 8'h13);
    n = 0;
    while (rstp_n == 1'b0 && n < 1000) begin
      n++;
      @(negedge clk); #1;
    end
    chk("R11 length", 8'(n), 8'd45);
    chk("R11 bit4 cleared", rdata, 8'h03);
    re = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_latch();
    t_irq();
    t_rearm();
    t_mask();
    t_set_wins();
    t_release();
    t_therm();
    t_init();
    t_pulse();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule